// File: doc/BRIEF.md
# Gated Capture Timer Channel

A single channel of a general-purpose 16-bit timer. It counts on the bus clock and is programmed through a small register interface with a write strobe and a combinational read. Two asynchronous pins, a capture input and a gate input, are synchronized inside the block. A chosen transition on the capture input copies the running count into a capture register. The gate input starts and stops counting in one of two styles. In restart style, a falling edge on the gate clears the count. In plain style, a falling edge only resumes counting.

The counter compares itself with a reference register. On a match it wraps to zero and toggles the timer output pin. A capture and a reference match each set a sticky event bit. Software clears an event bit by writing 1 to it. Each event bit, ANDed with its mask bit, drives the interrupt line.

Top module: `gcap_timer`

## Requirements
- R1: The capture-edge field MODE[4:3] selects the edge that loads the capture register with the count: 00 none, 01 rising, 10 falling, 11 both. Any other edge leaves the capture register unchanged.
- R2: A capture input change is first sampled at clock edge 1. The capture register and event bit 0 update at edge 3, and the value loaded is the count held just before edge 3.
- R3: While counting, when the count equals REF the next clock edge loads 0 into the count, toggles tmr_out and sets event bit 1.
- R4: EVT bit 0 is the capture event and bit 1 is the reference event. Both are sticky. Writing 1 to a bit clears it; writing 0 has no effect.
- R5: irq is high exactly when some EVT bit and the same MASK bit are both 1.
- R6: With MODE[1]=1 (gate enable) and MODE[2]=0 (restart style), a falling gate edge sampled at edge 1 zeroes the count and enables counting at edge 3. A rising gate edge stops counting: edge 3 is the last increment. Before the first falling edge after reset, the gate is closed.
- R7: With MODE[1]=1 and MODE[2]=1 (plain style), a falling gate edge enables counting from the held value without clearing it. Edge 3 leaves the value unchanged and edge 4 is the first increment.
- R8: With MODE[1]=0, the count increments on every clock while MODE[0] (run) is 1, whatever the gate input does.
- R9: After reset, count, capture, EVT, MASK and MODE are 0, REF is 16'hFFFF, tmr_out is 1, irq is 0 and the gate is closed.
- R10: The register addresses are 0 MODE, 1 REF, 2 CNT, 3 CAP (read only), 4 EVT and 5 MASK. Unused addresses read 0. A CNT write overrides counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| cap_in | input | 1 | Asynchronous capture input |
| gate_in | input | 1 | Asynchronous gate input |
| tmr_out | output | 1 | Timer output, toggles on each reference match |
| irq | output | 1 | Masked interrupt request |

## Verification
A register write lands on the first clock edge after the strobe is raised. The count read back at the following falling clock edge already shows the write. A pin change that is driven between edges is first sampled at the next edge. Its capture and gate effects are due at the third edge, and one more edge is needed before the count shows gate-driven counting. The bench drives pins and strobes on falling clock edges and counts falling edges to each expected update. It checks both the cycle before an update, where the old value must still hold, and the cycle of the update itself.

// File: rtl/gcap_timer.sv
module gcap_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic          cap_in,
  input  logic          gate_in,
  output logic          tmr_out,
  output logic          irq
);

  localparam logic [2:0] A_MODE = 3'd0, A_REF = 3'd1, A_CNT = 3'd2,
                         A_CAP  = 3'd3, A_EVT = 3'd4, A_MASK = 3'd5;

  logic [4:0]    mode_q;
  logic [CW-1:0] ref_q, cnt_q, cap_q;
  logic [1:0]    evt_q, mask_q;
  logic [2:0]    cap_sh, gate_sh;
  logic          gate_on;

  wire run      = mode_q[0];
  wire gate_en  = mode_q[1];
  wire gmode    = mode_q[2];
  wire [1:0] cap_edge = mode_q[4:3];

  wire cap_rise  =  cap_sh[1] & ~cap_sh[2];
  wire cap_fall  = ~cap_sh[1] &  cap_sh[2];
  wire gate_rise =  gate_sh[1] & ~gate_sh[2];
  wire gate_fall = ~gate_sh[1] &  gate_sh[2];

  wire cnt_wr    = wr_en && addr == A_CNT;
  wire evt_wr    = wr_en && addr == A_EVT;
  wire cap_hit   = (cap_edge[0] & cap_rise) | (cap_edge[1] & cap_fall);
  wire count_act = run && (!gate_en || gate_on);
  wire restart   = gate_en && !gmode && gate_fall;
  wire ref_hit   = count_act && cnt_q == ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sh  <= '0;
      gate_sh <= '0;
    end else begin
      cap_sh  <= {cap_sh[1:0], cap_in};
      gate_sh <= {gate_sh[1:0], gate_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '1;
      mask_q <= '0;
    end else if (wr_en) begin
      if (addr == A_MODE) mode_q <= wdata[4:0];
      if (addr == A_REF)  ref_q  <= wdata;
      if (addr == A_MASK) mask_q <= wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gate_on <= 1'b0;
    else if (gate_fall) gate_on <= 1'b1;
    else if (gate_rise) gate_on <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (cnt_wr)    cnt_q <= wdata;
    else if (restart)   cnt_q <= '0;
    else if (ref_hit)   cnt_q <= '0;
    else if (count_act) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (cap_hit) cap_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmr_out <= 1'b1;
    else if (ref_hit) tmr_out <= ~tmr_out;
  end

  logic [1:0] evt_n;
  always_comb begin
    evt_n = evt_q;
    if (evt_wr)  evt_n = evt_n & ~wdata[1:0];
    if (cap_hit) evt_n[0] = 1'b1;
    if (ref_hit) evt_n[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_n;
  end

  assign irq = |(evt_q & mask_q);

  always_comb begin
    case (addr)
      A_MODE:  rdata = CW'(mode_q);
      A_REF:   rdata = ref_q;
      A_CNT:   rdata = cnt_q;
      A_CAP:   rdata = cap_q;
      A_EVT:   rdata = CW'(evt_q);
      A_MASK:  rdata = CW'(mask_q);
      default: rdata = '0;
    endcase
  end

  AST_CAP_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_hit |=> $stable(cap_q)); // R1
  AST_REF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_act && cnt_q == ref_q && !cnt_wr) |=> (cnt_q == '0)); // R3
  AST_OUT_ONLY_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    !(count_act && cnt_q == ref_q) |=> $stable(tmr_out)); // R3
  AST_EVT_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_q[0]) |-> $past(wr_en && addr == A_EVT && wdata[0])); // R4
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != 2'b00)); // R5
  AST_GATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !gate_on && !gate_fall && !cnt_wr) |=> $stable(cnt_q)); // R6
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !gmode && gate_fall && !cnt_wr) |=> (cnt_q == '0)); // R6
  AST_NORMAL_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && gmode && gate_fall && !gate_on && !cnt_wr) |=> $stable(cnt_q)); // R7
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !gate_en && !cnt_wr && cnt_q != ref_q) |=> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R8

endmodule

// File: tb/gcap_timer_bench.sv
module gcap_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cap_in = 1'b0, gate_in = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic tmr_out, irq;
  int checks = 0, errors = 0;
  logic [15:0] v, c0, prev_cap;

  gcap_timer u_gcap_timer (.clk, .rst_n, .wr_en, .addr, .wdata, .rdata,
                           .cap_in, .gate_in, .tmr_out, .irq);

  always #5 clk = ~clk;

  // {edge select[1:0], rising transition, capture expected}
  localparam logic [3:0] VEC [8] = '{
    4'b00_1_0, 4'b00_0_0, 4'b01_1_1, 4'b01_0_0,
    4'b10_1_0, 4'b10_0_1, 4'b11_1_1, 4'b11_0_1 };

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R9 reset state
    chk("R9 tmr_out", 16'(tmr_out), 16'd1);
    chk("R9 irq", 16'(irq), 16'd0);
    rd(3'd2, v); chk("R9 cnt", v, 16'h0000);
    rd(3'd1, v); chk("R9 ref", v, 16'hFFFF);
    rd(3'd4, v); chk("R9 evt", v, 16'h0000);
    rd(3'd3, v); chk("R9 cap", v, 16'h0000);
    rd(3'd7, v); chk("R10 unused addr", v, 16'h0000);
    wait_n(6);
    rd(3'd2, v); chk("R9 stopped after reset", v, 16'h0000);

    // R1 edge select table, counter stopped so capture value is known
    prev_cap = 16'h0000;
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, 16'h0000);
      cap_in = ~VEC[i][1];
      wait_n(4);
      wr(3'd0, 16'(VEC[i][3:2]) << 3);
      wr(3'd2, 16'h1200 + 16'(i));
      wr(3'd4, 16'h0003);
      cap_in = VEC[i][1];
      wait_n(4);
      rd(3'd4, v); chk($sformatf("R1 evt vec %0d", i), 16'(v[0]), 16'(VEC[i][0]));
      if (VEC[i][0]) prev_cap = 16'h1200 + 16'(i);
      rd(3'd3, v); chk($sformatf("R1 cap vec %0d", i), v, prev_cap);
    end

    // R2 capture latency with a running counter
    wr(3'd0, 16'h0009);
    wr(3'd4, 16'h0003);
    rd(3'd2, c0);
    cap_in = 1'b1;
    wait_n(2);
    rd(3'd4, v); chk("R2 no event before edge 3", 16'(v[0]), 16'd0);
    wait_n(1);
    rd(3'd4, v); chk("R2 event at edge 3", 16'(v[0]), 16'd1);
    rd(3'd3, v); chk("R2 captured value", v, c0 + 16'd2);

    // R3 reference match
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h0005);
    wr(3'd2, 16'h0000);
    wait_n(5);
    rd(3'd2, v); chk("R3 count reaches ref", v, 16'd5);
    chk("R3 out before match", 16'(tmr_out), 16'd1);
    wait_n(1);
    rd(3'd2, v); chk("R3 wrap to zero", v, 16'd0);
    chk("R3 out toggled", 16'(tmr_out), 16'd0);
    rd(3'd4, v); chk("R3 ref event", 16'(v[1]), 16'd1);
    chk("R5 masked irq low", 16'(irq), 16'd0);

    // R4 / R5 event clearing and masking
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'h0002);
    chk("R5 irq with mask", 16'(irq), 16'd1);
    wr(3'd4, 16'h0001);
    rd(3'd4, v); chk("R4 clear bit0 only", v, 16'h0002);
    wr(3'd4, 16'h0000);
    rd(3'd4, v); chk("R4 write 0 ignored", v, 16'h0002);
    wr(3'd4, 16'h0002);
    rd(3'd4, v); chk("R4 clear bit1", v, 16'h0000);
    chk("R5 irq after clear", 16'(irq), 16'd0);

    // R6 restart gate style
    wr(3'd1, 16'hFFFF);
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'd100);
    wait_n(3);
    rd(3'd2, v); chk("R6 closed gate holds", v, 16'd100);
    gate_in = 1'b1;
    wait_n(4);
    rd(3'd2, v); chk("R6 rise keeps closed", v, 16'd100);
    gate_in = 1'b0;
    wait_n(2);
    rd(3'd2, v); chk("R6 before edge 3", v, 16'd100);
    wait_n(1);
    rd(3'd2, v); chk("R6 restart to zero", v, 16'd0);
    wait_n(2);
    rd(3'd2, v); chk("R6 counting", v, 16'd2);
    gate_in = 1'b1;
    wait_n(3);
    rd(3'd2, v); chk("R6 last increment", v, 16'd5);
    wait_n(2);
    rd(3'd2, v); chk("R6 stopped", v, 16'd5);

    // R7 plain gate style
    wr(3'd0, 16'h0007);
    gate_in = 1'b0;
    wait_n(3);
    rd(3'd2, v); chk("R7 no clear", v, 16'd5);
    wait_n(2);
    rd(3'd2, v); chk("R7 resumed", v, 16'd7);

    // R8 gate ignored when disabled
    gate_in = 1'b1;
    wait_n(5);
    rd(3'd2, v);
    wr(3'd0, 16'h0001);
    rd(3'd2, c0); chk("R8 held at switch", c0, v);
    wait_n(4);
    rd(3'd2, v); chk("R8 free running", v, c0 + 16'd4);

    // R10 count write overrides counting
    wr(3'd2, 16'h4000);
    rd(3'd2, v); chk("R10 cnt write wins", v, 16'h4000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule